// File: doc/BRIEF.md
# Head-Cache Replenishment Scheduler

This block schedules refills for the small on-chip head caches of a packet buffer that keeps many logical FIFOs, with the bulk of each FIFO held in wide, slow memory. In each slot a downstream scheduler may ask for one unit from any queue, and it is not known in advance which queue that will be. Bulk memory can only be reached once every B slots, and each access moves B units. The scheduler therefore picks which single queue receives the next B-unit refill.

Every request is held in a lookahead pipeline of NQ*(B-1)+1 slots before it is released as a grant. Because the block can see the requests that are already in that window, it knows how soon each queue's cached units will run out. At each refill opportunity it chooses the eligible queue that will run dry first, where eligible means the queue has at least B units waiting in bulk memory. It keeps a unit count per queue for the head cache and a unit count per queue for the bulk backlog. The backlog grows by B units whenever a block is written to bulk memory for that queue. If a grant leaves the pipeline while its queue's head cache is empty, the block raises a sticky underrun flag.

Top module: `hcr_sched`

## Requirements
- R1: While reset is high and in the first cycle after it falls, grant_vld, rep_vld and underrun are 0. All head-cache and backlog counts start at 0.
- R2: A request presented with req_vld=1 and queue req_q on a clock edge appears as grant_vld=1 with grant_q=req_q exactly L=NQ*(B-1)+1 cycles later. Here NQ is the number of queues and B is the transfer size. grant_vld is 0 in every other cycle.
- R3: rep_vld can be 1 only in cycles whose count since reset release is a multiple of B (B, 2B, ...). So there is at most one refill every B slots.
- R4: At a refill opportunity the queue is chosen using the requests currently in the window, from oldest to newest, and its current head-cache count. A queue's critical position is the first window position at which its running request count exceeds its head-cache count. The eligible queue with the smallest critical position is chosen, and rep_q names it.
- R5: A queue whose backlog is below B units is never chosen, even if it would become critical earliest. The choice then falls to the next eligible critical queue, or no refill is made.
- R6: When no eligible queue has a critical position inside the window, no refill is issued in that interval.
- R7: A refill adds B units to the chosen queue's head cache and removes B units from its backlog. These units can serve a grant leaving in the same slot as the refill.
- R8: underrun becomes 1 when a grant leaves while its queue's head cache holds 0 units, counting any refill in that same slot. Once set, it stays 1 until reset.
- R9: blk_vld with queue blk_q adds B units to that queue's backlog. The addition is ignored if the backlog already exceeds BULK_UNITS-B, where BULK_UNITS defaults to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | A one-unit read request is present this slot |
| req_q | input | QW | Queue named by the request |
| blk_vld | input | 1 | A B-unit block was written to bulk memory |
| blk_q | input | QW | Queue owning that block |
| grant_vld | output | 1 | Delayed request leaving the lookahead pipeline |
| grant_q | output | QW | Queue of the leaving request |
| rep_vld | output | 1 | Refill command this slot |
| rep_q | output | QW | Queue to refill with B units |
| underrun | output | 1 | Sticky: a grant found its head cache empty |

## Verification
A small directed refill test shows that one block plus one refill serves exactly B requests, and that the next request for that queue raises the sticky underrun. A further set of directed patterns separates the reasons a refill can go one way or the other: two eligible queues whose demand is ordered, an early-critical queue with no backlog set against a later one with backlog, full backlogs with no demand, and backlog additions pushed beyond capacity. A long constrained-random stream of requests and block arrivals is compared slot by slot with a bench model of the requirements. That comparison catches errors in the grant delay, in the refill phase, in the choice of queue and in the underrun flag.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int NQ_DEFAULT   = 4;
  localparam int B_DEFAULT    = 3;
  localparam int BULK_DEFAULT = 12;

  function automatic int lookahead_len(input int nq, input int b);
    return nq * (b - 1) + 1;
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hcr_window.sv
module hcr_window #(
  parameter int L  = 9,
  parameter int QW = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_vld,
  input  logic [QW-1:0]          in_q,
  output logic [L-1:0]           win_v,
  output logic [L-1:0][QW-1:0]   win_q
);
  // position 0 is the oldest entry, position L-1 the newest
  for (genvar i = 0; i < L; i++) begin : g_stage
    if (i == L - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) begin
          win_v[i] <= 1'b0;
          win_q[i] <= '0;
        end else begin
          win_v[i] <= in_vld;
          win_q[i] <= in_q;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          win_v[i] <= 1'b0;
          win_q[i] <= '0;
        end else begin
          win_v[i] <= win_v[i+1];
          win_q[i] <= win_q[i+1];
        end
      end
    end
  end
endmodule

// File: rtl/hcr_urgency.sv
module hcr_urgency #(
  parameter int L   = 9,
  parameter int QW  = 2,
  parameter int OW  = 4,
  parameter int PW  = 4,
  parameter int QID = 0
) (
  input  logic [L-1:0]         win_v,
  input  logic [L-1:0][QW-1:0] win_q,
  input  logic [OW-1:0]        occ,
  output logic                 crit,
  output logic [PW-1:0]        pos
);
  int cnt;

  always_comb begin
    cnt  = 0;
    crit = 1'b0;
    pos  = PW'(L);
    for (int p = 0; p < L; p++) begin
      if (!crit && win_v[p] && (win_q[p] == QW'(QID))) begin
        cnt = cnt + 1;
        if (cnt > int'(occ)) begin
          crit = 1'b1;
          pos  = PW'(p);
        end
      end
    end
  end
endmodule

// File: rtl/hcr_pick.sv
module hcr_pick #(
  parameter int NQ = 4,
  parameter int QW = 2,
  parameter int PW = 4
) (
  input  logic [NQ-1:0]         crit,
  input  logic [NQ-1:0]         elig,
  input  logic [NQ-1:0][PW-1:0] pos,
  output logic                  sel_v,
  output logic [QW-1:0]         sel_q
);
  logic [PW-1:0] best;

  always_comb begin
    sel_v = 1'b0;
    sel_q = '0;
    best  = '1;
    for (int q = 0; q < NQ; q++) begin
      if (crit[q] && elig[q] && (!sel_v || pos[q] < best)) begin
        sel_v = 1'b1;
        sel_q = QW'(q);
        best  = pos[q];
      end
    end
  end
endmodule

// File: rtl/hcr_sched.sv
module hcr_sched
  import hcr_pkg::*;
#(
  parameter int NQ         = NQ_DEFAULT,
  parameter int B          = B_DEFAULT,
  parameter int BULK_UNITS = BULK_DEFAULT,
  localparam int QW  = idx_width(NQ),
  localparam int L   = lookahead_len(NQ, B),
  localparam int OW  = $clog2(L + B + 1),
  localparam int PW  = $clog2(L + 1),
  localparam int BKW = $clog2(BULK_UNITS + 1),
  localparam int PHW = idx_width(B)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_vld,
  input  logic [QW-1:0] req_q,
  input  logic          blk_vld,
  input  logic [QW-1:0] blk_q,
  output logic          grant_vld,
  output logic [QW-1:0] grant_q,
  output logic          rep_vld,
  output logic [QW-1:0] rep_q,
  output logic          underrun
);
  logic [L-1:0]            win_v;
  logic [L-1:0][QW-1:0]    win_q;
  logic [NQ-1:0][OW-1:0]   occ_q, occ_d;
  logic [NQ-1:0][BKW-1:0]  bulk_q, bulk_d;
  logic [NQ-1:0]           crit, elig;
  logic [NQ-1:0][PW-1:0]   pos;
  logic                    sel_v;
  logic [QW-1:0]           sel_q;
  logic [PHW-1:0]          phase;
  logic                    rep_fire;
  logic                    empty_hit;

  hcr_window #(.L(L), .QW(QW)) u_win (
    .clk(clk), .rst(rst), .in_vld(req_vld), .in_q(req_q),
    .win_v(win_v), .win_q(win_q)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    hcr_urgency #(.L(L), .QW(QW), .OW(OW), .PW(PW), .QID(q)) u_urg (
      .win_v(win_v), .win_q(win_q), .occ(occ_q[q]),
      .crit(crit[q]), .pos(pos[q])
    );
    assign elig[q] = (bulk_q[q] >= BKW'(B));
  end

  hcr_pick #(.NQ(NQ), .QW(QW), .PW(PW)) u_pick (
    .crit(crit), .elig(elig), .pos(pos), .sel_v(sel_v), .sel_q(sel_q)
  );

  assign rep_fire = (phase == PHW'(B - 1)) && sel_v;

  always_comb begin
    logic [OW-1:0] t;
    logic          add;
    logic          inc;
    empty_hit = 1'b0;
    occ_d     = occ_q;
    bulk_d    = bulk_q;
    for (int q = 0; q < NQ; q++) begin
      add = rep_fire && (sel_q == QW'(q));
      t   = occ_q[q] + (add ? OW'(B) : OW'(0));
      if (win_v[0] && (win_q[0] == QW'(q))) begin
        if (t == '0) empty_hit = 1'b1;
        else         t = t - OW'(1);
      end
      occ_d[q] = t;
      inc = blk_vld && (blk_q == QW'(q)) &&
            (bulk_q[q] <= BKW'(BULK_UNITS - B));
      bulk_d[q] = bulk_q[q] + (inc ? BKW'(B) : BKW'(0))
                            - (add ? BKW'(B) : BKW'(0));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      occ_q     <= '0;
      bulk_q    <= '0;
      grant_vld <= 1'b0;
      grant_q   <= '0;
      rep_vld   <= 1'b0;
      rep_q     <= '0;
      underrun  <= 1'b0;
    end else begin
      phase     <= (phase == PHW'(B - 1)) ? '0 : phase + PHW'(1);
      occ_q     <= occ_d;
      bulk_q    <= bulk_d;
      grant_vld <= win_v[0];
      grant_q   <= win_q[0];
      rep_vld   <= rep_fire;
      rep_q     <= sel_q;
      underrun  <= underrun | empty_hit;
    end
  end
endmodule

// File: rtl/hcr_sched_chk.sv
module hcr_sched_chk #(
  parameter int NQ  = 4,
  parameter int B   = 3,
  parameter int QW  = 2,
  parameter int L   = 9,
  parameter int BKW = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_vld,
  input logic                   grant_vld,
  input logic                   rep_vld,
  input logic [QW-1:0]          rep_q,
  input logic                   underrun,
  input logic [NQ-1:0][BKW-1:0] bulk_q
);
  localparam int CW  = $clog2(L + 3);
  localparam int PHW = (B > 1) ? $clog2(B) : 1;

  logic [CW-1:0]          inflight;
  logic [PHW-1:0]         ph;
  logic [NQ-1:0][BKW-1:0] prev_bulk;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight  <= '0;
      ph        <= '0;
      prev_bulk <= '0;
    end else begin
      inflight  <= inflight + CW'(req_vld) - CW'(grant_vld);
      ph        <= (ph == PHW'(B - 1)) ? '0 : ph + PHW'(1);
      prev_bulk <= bulk_q;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!grant_vld && !rep_vld && !underrun));

  // R2
  grant_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> (inflight != '0));

  // R2
  inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(L + 1));

  // R3
  rep_phase_chk: assert property (@(posedge clk) disable iff (rst)
    rep_vld |-> (ph == '0));

  // R5
  rep_backlog_chk: assert property (@(posedge clk) disable iff (rst)
    rep_vld |-> (prev_bulk[rep_q] >= BKW'(B)));

  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);
endmodule

bind hcr_sched hcr_sched_chk #(
  .NQ(NQ), .B(B), .QW(QW), .L(L), .BKW(BKW)
) u_chk (
  .clk(clk), .rst(rst), .req_vld(req_vld), .grant_vld(grant_vld),
  .rep_vld(rep_vld), .rep_q(rep_q), .underrun(underrun), .bulk_q(bulk_q)
);

// File: tb/hcr_sched_tb.sv
module hcr_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NQ   = 4;
  localparam int B    = 3;
  localparam int BULK = 12;
  localparam int L    = NQ * (B - 1) + 1;
  localparam int QW   = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_vld = 1'b0, blk_vld = 1'b0;
  logic [QW-1:0] req_q = '0, blk_q = '0;
  logic          grant_vld, rep_vld, underrun;
  logic [QW-1:0] grant_q, rep_q;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  int m_occ[NQ], m_bulk[NQ], m_wv[L], m_wq[L];
  int m_phase, m_under;
  int exp_gv, exp_gq, exp_rv, exp_rq, exp_un;
  string exp_tag;
  int rep_cnt[NQ];
  int first_rep;

  hcr_sched #(.NQ(NQ), .B(B), .BULK_UNITS(BULK)) u_dut (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_q(req_q),
    .blk_vld(blk_vld), .blk_q(blk_q), .grant_vld(grant_vld),
    .grant_q(grant_q), .rep_vld(rep_vld), .rep_q(rep_q),
    .underrun(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R2 watchdog: cycles=%0d expected<%0d", cyc, 60000);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int q = 0; q < NQ; q++) begin
      m_occ[q] = 0; m_bulk[q] = 0; rep_cnt[q] = 0;
    end
    for (int p = 0; p < L; p++) begin m_wv[p] = 0; m_wq[p] = 0; end
    m_phase = 0; m_under = 0; first_rep = -1;
  endtask

  // expected behaviour of one slot, computed from the requirements
  task automatic model_step(input int rv, input int rq, input int bv, input int bq);
    int best, sel, fire, t, cnt, pos;
    exp_gv = m_wv[0]; exp_gq = m_wq[0];
    fire = 0; best = L; sel = 0;
    exp_tag = (m_phase == B - 1) ? "R6" : "R3";
    if (m_phase == B - 1) begin
      for (int q = 0; q < NQ; q++) begin
        cnt = 0; pos = -1;
        for (int p = 0; p < L; p++)
          if (pos < 0 && m_wv[p] && m_wq[p] == q) begin
            cnt++;
            if (cnt > m_occ[q]) pos = p;
          end
        if (pos >= 0) begin
          if (m_bulk[q] >= B) begin
            if (!fire || pos < best) begin fire = 1; best = pos; sel = q; end
          end else if (!fire) exp_tag = "R5";
        end
      end
      if (fire) exp_tag = "R4";
    end
    exp_rv = fire; exp_rq = sel;
    for (int q = 0; q < NQ; q++) begin
      t = m_occ[q] + ((fire && sel == q) ? B : 0);
      if (m_wv[0] && m_wq[0] == q) begin
        if (t == 0) m_under = 1; else t--;
      end
      m_occ[q] = t;
      m_bulk[q] = m_bulk[q] + ((bv && bq == q && m_bulk[q] <= BULK - B) ? B : 0)
                            - ((fire && sel == q) ? B : 0);
    end
    for (int p = 0; p < L - 1; p++) begin m_wv[p] = m_wv[p+1]; m_wq[p] = m_wq[p+1]; end
    m_wv[L-1] = rv; m_wq[L-1] = rq;
    m_phase = (m_phase == B - 1) ? 0 : m_phase + 1;
    exp_un = m_under;
  endtask

  task automatic step(input int rv, input int rq, input int bv, input int bq);
    req_vld = rv[0]; req_q = QW'(rq); blk_vld = bv[0]; blk_q = QW'(bq);
    model_step(rv, rq, bv, bq);
    @(posedge clk); #1;
    check(grant_vld == exp_gv[0], "R2", "grant_vld", grant_vld, exp_gv);
    if (exp_gv != 0) check(grant_q == QW'(exp_gq), "R2", "grant_q", grant_q, exp_gq);
    check(rep_vld == exp_rv[0], exp_tag, "rep_vld", rep_vld, exp_rv);
    if (exp_rv != 0) check(rep_q == QW'(exp_rq), "R4", "rep_q", rep_q, exp_rq);
    check(underrun == exp_un[0], "R8", "underrun", underrun, exp_un);
    if (rep_vld) begin
      rep_cnt[rep_q]++;
      if (first_rep < 0) first_rep = int'(rep_q);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1; req_vld = 0; blk_vld = 0; req_q = '0; blk_q = '0;
    repeat (3) @(posedge clk);
    #1;
    check(!grant_vld, "R1", "grant_vld in reset", grant_vld, 0);
    check(!rep_vld, "R1", "rep_vld in reset", rep_vld, 0);
    check(!underrun, "R1", "underrun in reset", underrun, 0);
    model_reset();
    rst = 0;
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));

    // R1 and R7: one block refills q1, serving exactly B requests
    do_reset();
    step(0, 0, 1, 1);
    for (int i = 0; i < B; i++) step(1, 1, 0, 0);
    idle(L + 4);
    check(rep_cnt[1] == 1, "R7", "refills of q1", rep_cnt[1], 1);
    check(!underrun, "R7", "underrun after served burst", underrun, 0);
    // R8: one more request with no backlog empties the cache
    step(1, 1, 0, 0);
    idle(L + 2);
    check(underrun, "R8", "underrun set", underrun, 1);
    idle(10);
    check(underrun, "R8", "underrun held", underrun, 1);

    // R4: q3 demanded before q0, both eligible
    do_reset();
    step(0, 0, 1, 3);
    step(0, 0, 1, 0);
    step(1, 3, 0, 0);
    step(1, 0, 0, 0);
    idle(L + 6);
    check(first_rep == 3, "R4", "first refill queue", first_rep, 3);
    check(rep_cnt[0] == 1, "R4", "refills of q0", rep_cnt[0], 1);

    // R5: q0 critical first but has no backlog; q2 is refilled
    do_reset();
    step(0, 0, 1, 2);
    step(1, 0, 0, 0);
    step(1, 2, 0, 0);
    idle(L + 6);
    check(rep_cnt[0] == 0, "R5", "refills of q0 without backlog", rep_cnt[0], 0);
    check(rep_cnt[2] == 1, "R5", "refills of q2", rep_cnt[2], 1);

    // R6: backlog everywhere, no demand
    do_reset();
    for (int q = 0; q < NQ; q++) step(0, 0, 1, q);
    idle(4 * B);
    check(rep_cnt[0] + rep_cnt[1] + rep_cnt[2] + rep_cnt[3] == 0,
          "R6", "refills without demand",
          rep_cnt[0] + rep_cnt[1] + rep_cnt[2] + rep_cnt[3], 0);

    // R9: five blocks for q3, capacity allows four
    do_reset();
    for (int i = 0; i < 5; i++) step(0, 0, 1, 3);
    for (int i = 0; i < 15; i++) step(1, 3, 0, 0);
    idle(L + 12);
    check(rep_cnt[3] == BULK / B, "R9", "refills of q3 at capacity", rep_cnt[3], BULK / B);

    // constrained random traffic, compared slot by slot
    do_reset();
    for (int i = 0; i < 1500; i++) begin
      int rv, bv;
      rv = (($urandom % 10) < 8) ? 1 : 0;
      bv = (($urandom % 10) < 3) ? 1 : 0;
      step(rv, int'($urandom % NQ), bv, int'($urandom % NQ));
    end
    idle(L + 2);

    done = 1;
    summary();
    $finish;
  end
endmodule